// File: doc/BRIEF.md
# UART Receive Address-Match Filter

This block sits between a UART receiver's frame assembler and its receive data buffer, and it decides which completed frames reach the buffer. Each frame comes with a marker bit, which is the bit received just before the stop bit. A frame with the marker set is an address frame. A frame with the marker clear is a data frame.

When filtering is active, an address frame is compared with up to two match slots, and each slot has its own enable. The result of that comparison is remembered. The data frames that follow a matching address are written to the buffer, and those that follow a non-matching address are dropped. With both slots disabled, or with smart-card mode active, every frame is written unchanged. A sticky data-ready flag rises with every write and is cleared by a read acknowledge from the buffer side.

The controller is a three-state machine:
- `ST_PASS`: filtering is off.
- `ST_HUNT`: the last address did not match, or there has been no address since the filter was turned on.
- `ST_LOCK`: the last address matched.

Its transitions are:
- Any state goes to `ST_PASS` in the cycle that filtering turns off.
- `ST_PASS` or `ST_HUNT` goes to `ST_LOCK` on a matching address frame.
- `ST_PASS` goes to `ST_HUNT` on any other cycle with filtering on.
- `ST_LOCK` goes to `ST_HUNT` on a non-matching address frame.
- `ST_LOCK` stays in `ST_LOCK` on data frames and on matching address frames.

Top module: `rxf_addr_gate`

## Requirements
- R1: A frame whose marker input `frm_mark` is 1 is handled as an address frame. A frame whose marker is 0 is handled as a data frame.
- R2: While filtering is active, an address frame is written only if its 8 data bits, compared as an unsigned value with the marker excluded, equal the address of an enabled slot. An address frame that matches no enabled slot is not written and does not set the ready flag.
- R3: After a matching address frame, every following data frame is written until the next address frame arrives.
- R4: After a non-matching address frame, every following data frame is dropped. A later matching address frame resumes delivery.
- R5: With both slot enables at 0, every frame is written, including marked frames. This takes effect in the same cycle the enables clear, with no new address frame needed.
- R6: With only one slot enabled, an address frame is compared only against that slot's address. A frame that equals the disabled slot's address is rejected.
- R7: With both slots enabled, an address frame is accepted if it equals either slot's address.
- R8: While `card_mode` is 1, filtering is bypassed and every frame is written, whatever the enables are set to.
- R9: After reset, `buf_wr` and `data_ready` are 0 and the match state is "not matched". Data frames that arrive before any address frame are dropped while filtering is active. Turning filtering back on after pass-through also starts from "not matched".
- R10: A frame is written as a single-cycle `buf_wr` pulse in the clock cycle after the cycle in which `frm_valid` is sampled. `buf_data` carries the frame's 8 data bits in that cycle.
- R11: `data_ready` becomes 1 with every write and stays at 1 until a cycle with `rd_ack` at 1 and no write. A write in the same cycle as `rd_ack` leaves it at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | Completed frame present this cycle |
| frm_data | input | 8 | Frame data bits, marker excluded |
| frm_mark | input | 1 | Bit just before the stop bit; 1 means address frame |
| slot_a_en | input | 1 | Enable for match slot A |
| slot_b_en | input | 1 | Enable for match slot B |
| slot_a_addr | input | 8 | Address held by match slot A |
| slot_b_addr | input | 8 | Address held by match slot B |
| card_mode | input | 1 | Smart-card mode; bypasses filtering |
| rd_ack | input | 1 | Buffer read acknowledge; clears the ready flag |
| buf_wr | output | 1 | Write strobe to the receive buffer |
| buf_data | output | 8 | Data written to the receive buffer |
| data_ready | output | 1 | Sticky data-ready flag |

## Verification
A wrong match state shows up at the ports only when the next data frame arrives. A state wrongly left in `ST_LOCK` produces a `buf_wr` pulse one cycle after that frame, and a state wrongly left in `ST_HUNT` produces a missing pulse in that same cycle. For this reason the stimulus always follows each address frame with one or more data frames, and it revisits the state after each change to an enable or to smart-card mode. A wrong ready flag is visible in the cycle of the write and again after the acknowledge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int FRAME_W   = 8;
    localparam int NUM_SLOTS = 2;

    typedef enum logic [1:0] {
        ST_PASS = 2'd0,
        ST_HUNT = 2'd1,
        ST_LOCK = 2'd2
    } gate_state_e;

endpackage

// File: rtl/rxf_slot_cmp.sv
module rxf_slot_cmp #(
    parameter int W = 8
) (
    input  logic         slot_en,
    input  logic [W-1:0] slot_addr,
    input  logic [W-1:0] frame_bits,
    output logic         hit
);

    // Unsigned equality on data bits only; a disabled slot never hits.
    always_comb begin
        hit = slot_en && (frame_bits == slot_addr);
    end

endmodule

// File: rtl/rxf_ctrl_fsm.sv
module rxf_ctrl_fsm
    import rxf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frm_valid,
    input  logic        frm_mark,
    input  logic        filt_on,
    input  logic        any_hit,
    output gate_state_e state,
    output logic        accept
);

    gate_state_e state_nx;
    logic        is_addr;
    logic        is_data;

    always_comb begin
        is_addr = frm_valid && frm_mark;
        is_data = frm_valid && !frm_mark;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        if (!filt_on) begin
            state_nx = ST_PASS;
        end else begin
            unique case (state)
                ST_PASS: state_nx = (is_addr && any_hit) ? ST_LOCK : ST_HUNT;
                ST_HUNT: state_nx = (is_addr && any_hit) ? ST_LOCK : ST_HUNT;
                ST_LOCK: state_nx = (is_addr && !any_hit) ? ST_HUNT : ST_LOCK;
                default: state_nx = ST_HUNT;
            endcase
        end
    end

    // Delivery decision
    always_comb begin
        accept = 1'b0;
        if (!filt_on) begin
            accept = frm_valid;
        end else if (is_addr) begin
            accept = any_hit;
        end else if (is_data) begin
            unique case (state)
                ST_LOCK: accept = 1'b1;
                ST_HUNT: accept = 1'b0;
                ST_PASS: accept = 1'b0;
                default: accept = 1'b0;
            endcase
        end
    end

    AST_HIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_on && is_addr && any_hit) |=> (state == ST_LOCK)); // R3
    AST_MISS_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_on && is_addr && !any_hit) |=> (state == ST_HUNT)); // R4
    AST_OFF_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (!filt_on) |=> (state == ST_PASS)); // R5

endmodule

// File: rtl/rxf_out_stage.sv
module rxf_out_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept,
    input  logic [W-1:0] frame_bits,
    input  logic         rd_ack,
    output logic         buf_wr,
    output logic [W-1:0] buf_data,
    output logic         data_ready
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_wr   <= 1'b0;
            buf_data <= '0;
        end else begin
            buf_wr <= accept;
            if (accept) begin
                buf_data <= frame_bits;
            end
        end
    end

    // Set has priority over acknowledge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_ready <= 1'b0;
        end else if (accept) begin
            data_ready <= 1'b1;
        end else if (rd_ack) begin
            data_ready <= 1'b0;
        end
    end

    AST_RDY_ON_WR: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> data_ready); // R11
    AST_RDY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && !rd_ack) |=> data_ready); // R11

endmodule

// File: rtl/rxf_addr_gate.sv
module rxf_addr_gate
    import rxf_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frm_valid,
    input  logic [W-1:0] frm_data,
    input  logic         frm_mark,
    input  logic         slot_a_en,
    input  logic         slot_b_en,
    input  logic [W-1:0] slot_a_addr,
    input  logic [W-1:0] slot_b_addr,
    input  logic         card_mode,
    input  logic         rd_ack,
    output logic         buf_wr,
    output logic [W-1:0] buf_data,
    output logic         data_ready
);

    localparam int NS = NUM_SLOTS;

    logic [NS-1:0] slot_en;
    logic [W-1:0]  slot_addr [NS];
    logic [NS-1:0] slot_hit;
    logic          any_hit;
    logic          filt_on;
    logic          accept;
    gate_state_e   state;

    always_comb begin
        slot_en      = {slot_b_en, slot_a_en};
        slot_addr[0] = slot_a_addr;
        slot_addr[1] = slot_b_addr;
        any_hit      = |slot_hit;
        filt_on      = (|slot_en) && !card_mode;
    end

    for (genvar g = 0; g < NS; g++) begin : g_slot
        rxf_slot_cmp #(.W(W)) u_cmp (
            .slot_en    (slot_en[g]),
            .slot_addr  (slot_addr[g]),
            .frame_bits (frm_data),
            .hit        (slot_hit[g])
        );
    end

    rxf_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .frm_mark  (frm_mark),
        .filt_on   (filt_on),
        .any_hit   (any_hit),
        .state     (state),
        .accept    (accept)
    );

    rxf_out_stage #(.W(W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .frame_bits (frm_data),
        .rd_ack     (rd_ack),
        .buf_wr     (buf_wr),
        .buf_data   (buf_data),
        .data_ready (data_ready)
    );

    AST_PASS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && (card_mode || (!slot_a_en && !slot_b_en)))
        |=> (buf_wr && buf_data == $past(frm_data))); // R5
    AST_ADDR_MISS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_mark && !card_mode && (slot_a_en || slot_b_en)
         && !(slot_a_en && frm_data == slot_a_addr)
         && !(slot_b_en && frm_data == slot_b_addr)) |=> !buf_wr); // R2
    AST_HUNT_DATA_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !frm_mark && filt_on && state != ST_LOCK) |=> !buf_wr); // R4
    AST_WR_FOLLOWS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> $past(frm_valid)); // R10

endmodule

// File: tb/tb_rxf_addr_gate.sv
module tb_rxf_addr_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_valid = 1'b0;
    logic [7:0] frm_data = '0;
    logic       frm_mark = 1'b0;
    logic       slot_a_en = 1'b0;
    logic       slot_b_en = 1'b0;
    logic [7:0] slot_a_addr = 8'h21;
    logic [7:0] slot_b_addr = 8'h5A;
    logic       card_mode = 1'b0;
    logic       rd_ack = 1'b0;
    logic       buf_wr;
    logic [7:0] buf_data;
    logic       data_ready;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    rxf_addr_gate dut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
        .frm_mark(frm_mark), .slot_a_en(slot_a_en), .slot_b_en(slot_b_en),
        .slot_a_addr(slot_a_addr), .slot_b_addr(slot_b_addr),
        .card_mode(card_mode), .rd_ack(rd_ack), .buf_wr(buf_wr),
        .buf_data(buf_data), .data_ready(data_ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // {a_en, b_en, card, mark, data[7:0], exp_wr, req[3:0]}
    localparam int NV = 24;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,1'b0,8'h33,1'b0,4'd9},  // R9 data before any address
        {1'b1,1'b0,1'b0,1'b1,8'h5A,1'b0,4'd6},  // R6 slot B disabled
        {1'b1,1'b0,1'b0,1'b0,8'h44,1'b0,4'd4},  // R4 / R1 data after miss
        {1'b1,1'b0,1'b0,1'b1,8'h21,1'b1,4'd2},  // R2 / R1 address hit
        {1'b1,1'b0,1'b0,1'b0,8'h77,1'b1,4'd3},  // R3
        {1'b1,1'b0,1'b0,1'b0,8'h78,1'b1,4'd3},  // R3 sticky
        {1'b1,1'b0,1'b0,1'b1,8'hA1,1'b0,4'd2},  // R2 near miss
        {1'b1,1'b0,1'b0,1'b0,8'h79,1'b0,4'd4},  // R4
        {1'b0,1'b1,1'b0,1'b1,8'h21,1'b0,4'd6},  // R6 slot A disabled
        {1'b0,1'b1,1'b0,1'b1,8'h5A,1'b1,4'd6},  // R6 own slot
        {1'b0,1'b1,1'b0,1'b0,8'h10,1'b1,4'd3},  // R3
        {1'b1,1'b1,1'b0,1'b1,8'h21,1'b1,4'd7},  // R7 hit A
        {1'b1,1'b1,1'b0,1'b0,8'h11,1'b1,4'd3},  // R3
        {1'b1,1'b1,1'b0,1'b1,8'h5A,1'b1,4'd7},  // R7 hit B
        {1'b1,1'b1,1'b0,1'b1,8'h00,1'b0,4'd7},  // R7 miss both
        {1'b1,1'b1,1'b0,1'b0,8'h12,1'b0,4'd4},  // R4
        {1'b0,1'b0,1'b0,1'b0,8'h13,1'b1,4'd5},  // R5 immediate
        {1'b0,1'b0,1'b0,1'b1,8'h99,1'b1,4'd5},  // R5 marked passes
        {1'b1,1'b1,1'b0,1'b0,8'h14,1'b0,4'd9},  // R9 re-enable
        {1'b1,1'b1,1'b1,1'b0,8'h15,1'b1,4'd8},  // R8
        {1'b1,1'b1,1'b1,1'b1,8'hEE,1'b1,4'd8},  // R8
        {1'b1,1'b1,1'b0,1'b0,8'h16,1'b0,4'd9},  // R9 after card mode
        {1'b1,1'b1,1'b0,1'b1,8'h5A,1'b1,4'd7},  // R7
        {1'b1,1'b1,1'b0,1'b0,8'h17,1'b1,4'd3}   // R3
    };

    task automatic send(input logic m, input logic [7:0] d);
        frm_mark  = m;
        frm_data  = d;
        frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset buf_wr", buf_wr, 0);
        check("R9 reset data_ready", data_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            slot_a_en = VEC[i][16];
            slot_b_en = VEC[i][15];
            card_mode = VEC[i][14];
            send(VEC[i][13], VEC[i][12:5]);
            check($sformatf("R%0d vec%0d buf_wr", VEC[i][3:0], i), buf_wr, VEC[i][4]);
            if (VEC[i][4])
                check($sformatf("R%0d vec%0d buf_data", VEC[i][3:0], i), buf_data, VEC[i][12:5]);
            check($sformatf("R%0d vec%0d data_ready", VEC[i][3:0], i), data_ready, VEC[i][4]);
            rd_ack = 1'b1;
            @(negedge clk);
            rd_ack = 1'b0;
            @(negedge clk);
        end

        // R10: pulse is one cycle wide; R11: flag stickiness
        slot_a_en = 1'b0; slot_b_en = 1'b0; card_mode = 1'b0;
        send(1'b0, 8'hC3);
        check("R10 pulse", buf_wr, 1);
        check("R10 data", buf_data, 8'hC3);
        @(negedge clk);
        check("R10 single cycle", buf_wr, 0);
        repeat (3) @(negedge clk);
        check("R11 ready holds", data_ready, 1);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        check("R11 ready cleared", data_ready, 0);
        rd_ack = 1'b1;
        send(1'b0, 8'h3C);
        rd_ack = 1'b0;
        check("R11 write beats ack", data_ready, 1);

        // R9: reset mid-lock returns to not matched
        slot_a_en = 1'b1;
        send(1'b1, 8'h21);
        check("R2 lock before reset", buf_wr, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears ready", data_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        send(1'b0, 8'h55);
        check("R9 not matched after reset", buf_wr, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule